// File: doc/BRIEF.md
# Infrared Edge Interval Timer

This block times the alternating marks and spaces on a demodulated infrared receiver line, so that software can decode any remote-control protocol from the raw interval list. The input is first passed through a synchronizer. It then goes through a deglitch filter that counts ticks: a new level is accepted only after it has stayed stable for a programmable number of ticks. A prescaler derives a tick of `base_time + 1` clock cycles. With a 1 MHz reference and `base_time = 9`, this gives the usual 10 µs resolution.

An edge is selected by a two-bit mode field. On each selected edge, the block latches three things: the number of ticks since the previous selected edge, a flag telling whether the interval that just ended was a mark, and a one-cycle interrupt strobe. The tick prescaler and the interval counter then restart from zero. The interval counter stops at full scale and does not wrap. A soft clear input and an enable input let the block be parked and re-armed. A register bus wrapper and protocol decoding sit outside the block.

Top module: `ir_edge_timer`

## Requirements
- R1: With `filter_len` = 0, the `duration` latched at a selected edge equals floor(D / (`base_time` + 1)). Here D is the number of clock cycles between that edge and the previous selected edge at `ir_in`.
- R2: The interval count saturates at 2^DUR_W − 1 and does not wrap. A long interval therefore reads as full scale, and an interval one tick short of full scale reads exactly.
- R3: `edge_sel` = 1 selects both edges, 2 selects falling edges (high to low) only, and 3 selects rising edges (low to high) only. Exactly one `irq` strobe is raised per selected edge.
- R4: `edge_sel` = 0 is reserved for decoder events and selects no line edge. In this mode `irq` stays low and `duration` keeps its value.
- R5: `pulse_flag` is 1 when the interval that ended was a mark and 0 when it was a space. With ACTIVE_LOW = 1, a mark is `ir_in` low. A rising edge therefore latches 1 and a falling edge latches 0.
- R6: A level change is accepted only after `ir_in` has held the new level for `filter_len` ticks. A change that covers fewer ticks raises no `irq`.
- R7: `soft_clr` takes priority over `enable`. One cycle after it, `duration`, `pulse_flag` and `irq` are 0.
- R8: While `enable` is low, no `irq` is raised and `duration` and `pulse_flag` hold their values.
- R9: `duration` and `pulse_flag` change only in the cycle where `irq` is high, apart from a clear. After reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of the capture logic |
| enable | input | 1 | Capture enable |
| base_time | input | PRESC_W | Tick period minus one, in clock cycles |
| filter_len | input | FILT_W | Ticks a new level must hold before acceptance |
| edge_sel | input | 2 | Interrupt edge mode |
| ir_in | input | 1 | Demodulated infrared line (asynchronous) |
| duration | output | DUR_W | Ticks in the interval that ended |
| pulse_flag | output | 1 | Ended interval was a mark |
| irq | output | 1 | One-cycle strobe on each selected edge |

## Verification
The bench builds the block with DUR_W = 6 and PRESC_W = 4, so full scale is only 63 ticks. At that size, saturation and the values just below and just above it can be reached in a few hundred cycles. A sweep over `base_time` from 0 to 7, crossed with interval lengths from 4 to 46 cycles, checks the floor-division rule for every tick phase on both mark and space intervals. The short tick also makes it practical to place a glitch that spans exactly two ticks against a filter setting of three.

// File: rtl/ir_edge_pkg.sv
package ir_edge_pkg;
   typedef enum logic [1:0] {
      EDGE_DECODER = 2'd0,
      EDGE_BOTH    = 2'd1,
      EDGE_FALL    = 2'd2,
      EDGE_RISE    = 2'd3
   } edge_mode_e;
endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         restart,
   input  logic [W-1:0] period_m1,
   output logic         tick
);
   logic [W-1:0] cnt;

   assign tick = run && (cnt >= period_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (!run || restart || tick) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ir_deglitch.sv
module ir_deglitch #(
   parameter int   FW      = 3,
   parameter logic RST_VAL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          din,
   input  logic [FW-1:0] thresh,
   output logic          level,
   output logic          accept
);
   localparam logic [FW-1:0] STAB_MAX = '1;
   logic [FW-1:0] stab;

   assign accept = run && (din != level) && (stab >= thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= RST_VAL;
         stab  <= '0;
      end else if (!run) begin
         level <= din;
         stab  <= '0;
      end else if (din == level) begin
         stab  <= '0;
      end else if (accept) begin
         level <= din;
         stab  <= '0;
      end else if (tick && stab != STAB_MAX) begin
         stab  <= stab + 1'b1;
      end
   end
endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer
   import ir_edge_pkg::*;
#(
   parameter int DUR_W       = 13,
   parameter int PRESC_W     = 12,
   parameter int FILT_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_LOW  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr,
   input  logic               enable,
   input  logic [PRESC_W-1:0] base_time,
   input  logic [FILT_W-1:0]  filter_len,
   input  logic [1:0]         edge_sel,
   input  logic               ir_in,
   output logic [DUR_W-1:0]   duration,
   output logic               pulse_flag,
   output logic               irq
);
   localparam logic             IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;
   localparam logic [DUR_W-1:0] DUR_MAX  = '1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DUR_W < 2 || PRESC_W < 1 || FILT_W < 1) begin : g_bad_width
      $error("DUR_W must be >= 2, PRESC_W and FILT_W >= 1");
   end

   logic run, line_s, lvl, accept, tick, sel, ended_mark;
   logic [DUR_W-1:0] ivl, ivl_now;

   assign run = enable & ~soft_clr;

   ir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ir_in), .q(line_s)
   );

   ir_tick_gen #(.W(PRESC_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(sel),
      .period_m1(base_time), .tick(tick)
   );

   ir_deglitch #(.FW(FILT_W), .RST_VAL(IDLE_LVL)) u_filt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .din(line_s),
      .thresh(filter_len), .level(lvl), .accept(accept)
   );

   always_comb begin
      case (edge_mode_e'(edge_sel))
         EDGE_BOTH: sel = accept;
         EDGE_FALL: sel = accept & lvl;
         EDGE_RISE: sel = accept & ~lvl;
         default:   sel = 1'b0;
      endcase
   end

   if (ACTIVE_LOW) begin : g_mark_low
      assign ended_mark = ~lvl;
   end else begin : g_mark_high
      assign ended_mark = lvl;
   end

   assign ivl_now = (tick && ivl != DUR_MAX) ? ivl + 1'b1 : ivl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivl        <= '0;
         duration   <= '0;
         pulse_flag <= 1'b0;
         irq        <= 1'b0;
      end else if (soft_clr) begin
         ivl        <= '0;
         duration   <= '0;
         pulse_flag <= 1'b0;
         irq        <= 1'b0;
      end else begin
         irq <= sel;
         if (!enable) begin
            ivl <= '0;
         end else if (sel) begin
            duration   <= ivl_now;
            pulse_flag <= ended_mark;
            ivl        <= '0;
         end else begin
            ivl <= ivl_now;
         end
      end
   end
endmodule

// File: rtl/ir_edge_timer_chk.sv
module ir_edge_timer_chk #(
   parameter int DUR_W      = 13,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_clr,
   input logic             enable,
   input logic [1:0]       edge_sel,
   input logic [DUR_W-1:0] duration,
   input logic             pulse_flag,
   input logic             irq
);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !$past(soft_clr)) |-> ($stable(duration) && $stable(pulse_flag)));

   p_no_decoder_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(edge_sel) == 2'd0) |-> !irq);

   p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> !irq);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_clr) |-> (duration == '0 && !pulse_flag && !irq));

   p_fall_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(edge_sel) == 2'd2) |-> (pulse_flag == !ACTIVE_LOW));

   p_rise_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(edge_sel) == 2'd3) |-> (pulse_flag == ACTIVE_LOW));
endmodule

bind ir_edge_timer ir_edge_timer_chk #(.DUR_W(DUR_W), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .enable(enable),
   .edge_sel(edge_sel), .duration(duration), .pulse_flag(pulse_flag), .irq(irq)
);

// File: tb/ir_edge_timer_bench.sv
module ir_edge_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DUR_W      = 6;
   localparam int PRESC_W    = 4;
   localparam int FILT_W     = 3;
   localparam int DUR_MAX    = (1 << DUR_W) - 1;

   logic               clk = 1'b0;
   logic               rst_n, soft_clr, enable, ir_in;
   logic [PRESC_W-1:0] base_time;
   logic [FILT_W-1:0]  filter_len;
   logic [1:0]         edge_sel;
   logic [DUR_W-1:0]   duration;
   logic               pulse_flag, irq;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   int last_dur = 0;
   int last_pol = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ir_edge_timer #(.DUR_W(DUR_W), .PRESC_W(PRESC_W), .FILT_W(FILT_W)) u_ir_edge_timer (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .enable(enable),
      .base_time(base_time), .filter_len(filter_len), .edge_sel(edge_sel),
      .ir_in(ir_in), .duration(duration), .pulse_flag(pulse_flag), .irq(irq)
   );

   always @(negedge clk) begin
      if (irq) begin
         irq_cnt  <= irq_cnt + 1;
         last_dur <= int'(duration);
         last_pol <= int'(pulse_flag);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int c0, d0, prev;
      rst_n = 1'b0; soft_clr = 1'b0; enable = 1'b0; ir_in = 1'b1;
      base_time = '0; filter_len = '0; edge_sel = 2'd1;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R9 reset duration", int'(duration), 0);
      chk("R9 reset flag", int'(pulse_flag), 0);
      chk("R9 reset irq", int'(irq), 0);
      enable = 1'b1;
      cyc(2);

      // R1 / R5 sweep over tick period and interval length, both edges
      c0 = irq_cnt;
      for (int b = 0; b < 8; b++) begin
         base_time = PRESC_W'(b);
         prev = -1;
         for (int d = 4; d <= 46; d += 3) begin
            ir_in = 1'b0;
            cyc(4);
            if (prev >= 0) begin
               chk("R1 space duration", last_dur, prev / (b + 1));
               chk("R5 space flag", last_pol, 0);
            end
            cyc(d - 4);
            ir_in = 1'b1;
            cyc(4);
            chk("R1 mark duration", last_dur, d / (b + 1));
            chk("R5 mark flag", last_pol, 1);
            cyc(d - 4);
            prev = d;
         end
      end
      chk("R3 both-edge irq count", irq_cnt - c0, 8 * 15 * 2);

      // R3 falling only
      base_time = 4'd1; edge_sel = 2'd2; c0 = irq_cnt;
      ir_in = 1'b0; cyc(10); ir_in = 1'b1; cyc(14); ir_in = 1'b0; cyc(5);
      chk("R3 falling irq count", irq_cnt - c0, 2);
      chk("R1 falling duration", last_dur, 24 / 2);
      chk("R5 falling flag", last_pol, 0);

      // R3 rising only
      edge_sel = 2'd3; c0 = irq_cnt;
      ir_in = 1'b1; cyc(7); ir_in = 1'b0; cyc(9); ir_in = 1'b1; cyc(5);
      chk("R3 rising irq count", irq_cnt - c0, 2);
      chk("R1 rising duration", last_dur, 16 / 2);
      chk("R5 rising flag", last_pol, 1);

      // R4 decoder mode: no edges selected
      edge_sel = 2'd0; c0 = irq_cnt; d0 = int'(duration);
      ir_in = 1'b0; cyc(6); ir_in = 1'b1; cyc(6);
      chk("R4 irq count", irq_cnt - c0, 0);
      chk("R4 duration held", int'(duration), d0);

      // R2 saturation
      edge_sel = 2'd1; base_time = 4'd0;
      ir_in = 1'b0; cyc(80); ir_in = 1'b1; cyc(4);
      chk("R2 saturated", last_dur, DUR_MAX);
      ir_in = 1'b0; cyc(62); ir_in = 1'b1; cyc(4);
      chk("R2 below full scale", last_dur, 62);
      ir_in = 1'b0; cyc(63); ir_in = 1'b1; cyc(4);
      chk("R2 at full scale", last_dur, 63);
      ir_in = 1'b0; cyc(64); ir_in = 1'b1; cyc(4);
      chk("R2 no wrap", last_dur, DUR_MAX);
      base_time = 4'd2;
      ir_in = 1'b0; cyc(200); ir_in = 1'b1; cyc(4);
      chk("R2 saturated slow tick", last_dur, DUR_MAX);

      // R8 disabled
      enable = 1'b0; c0 = irq_cnt; d0 = int'(duration);
      ir_in = 1'b0; cyc(8); ir_in = 1'b1; cyc(8);
      chk("R8 irq count", irq_cnt - c0, 0);
      chk("R8 duration held", int'(duration), d0);
      chk("R8 flag held", int'(pulse_flag), 1);
      enable = 1'b1; cyc(2);

      // R7 soft clear with enable high
      soft_clr = 1'b1; cyc(1); soft_clr = 1'b0;
      chk("R7 duration cleared", int'(duration), 0);
      chk("R7 flag cleared", int'(pulse_flag), 0);
      chk("R7 irq low", int'(irq), 0);
      cyc(4);

      // R6 deglitch filter: 3 ticks of 4 cycles
      base_time = 4'd3; filter_len = 3'd3; c0 = irq_cnt;
      ir_in = 1'b0; cyc(8); ir_in = 1'b1; cyc(20);
      chk("R6 glitch rejected", irq_cnt - c0, 0);
      ir_in = 1'b0; cyc(30);
      chk("R6 held level accepted", irq_cnt - c0, 1);
      chk("R5 filtered space flag", last_pol, 0);

      summary();
   end
endmodule